// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This block keeps a free-running 32-bit time counter and records timestamped events into a 16-entry queue. Each queued entry pairs a 32-bit timestamp with a 32-bit descriptor word. The descriptor carries an event kind, a port or pin number, a message type and a sequence number.

Events come from several places. Software can request a push through a register write. The counter logs its own wrap to zero and its crossing into the upper half of its range. Four external pins are synchronised and captured on their rising edges. Ethernet receive and transmit strobes carry their own port, message type and sequence number. When several events arrive in the same cycle, they are held in one-deep per-source slots and moved into the queue one per cycle, in a fixed priority order.

Software reads the head of the queue as a low word and a high word, then discards it with a pop write. A pending flag, which can be forced by a test bit, is gated by an enable bit to form the interrupt output. When the queue is full, further events are dropped and a sticky overflow flag is raised.

Top module: `ts_event_unit`

## Requirements
- R1: After reset the counter is 0, the queue is empty, `irq` is 0, and every readable register reads 0.
- R2: While control bit 0 (address 0) is 1, the counter increments once per cycle; while it is 0, the counter holds. Writing 1 to bit 0 of address 3 copies the load value (address 2) into the counter on that edge.
- R3: Writing 1 to bit 0 of address 1 queues an event of kind 0. Its timestamp is the counter value in the cycle the write is sampled.
- R4: A counter step from 0xFFFFFFFF to 0 queues kind 1 with timestamp 0. A step from 0x7FFFFFFF to 0x80000000 queues kind 2 with timestamp 0x80000000. A load never raises either event.
- R5: Pin k (k = 0..3) passes through a two-flop synchroniser and is captured on its rising edge, provided control bit 8+k is 1. It queues kind 3 with port number k+1. With control bit 8+k at 0 the pin queues nothing.
- R6: A receive strobe queues kind 4 and a transmit strobe queues kind 5. Each carries the port, message type and sequence inputs sampled with the strobe.
- R7: The descriptor word has port in bits 28:24, kind in bits 23:20, message type in bits 19:16 and sequence in bits 15:0. Bits 31:29 are 0. Kinds other than 3, 4 and 5 have port, message and sequence 0.
- R8: Address 8 reads the head timestamp and address 9 reads the head descriptor; both read 0 when the queue is empty. Writing 1 to bit 0 of address 7 removes exactly one head entry. On an empty queue it has no effect.
- R9: Address 4 bit 0 (raw) is 1 when the queue is non-empty or control bit 1 is set. Address 5 bit 0 is raw AND address 6 bit 0. `irq` equals address 5 bit 0.
- R10: Events raised in the same cycle enter the queue one per cycle, in this order: wrap, half-wrap, software push, pins 1..4, receive, transmit. All of them keep the timestamp of the cycle in which they were raised.
- R11: When the queue holds 16 entries, a new entry is dropped and address 10 bit 0 becomes 1 and stays 1. Writing 1 to bit 0 of address 10 clears it.
- R12: While control bit 0 is 0, no event of any kind is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| hw_pin | input | 4 | Asynchronous capture pins |
| rx_stb | input | 1 | Receive timestamp strobe |
| rx_port | input | 5 | Receive port number |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence number |
| tx_stb | input | 1 | Transmit timestamp strobe |
| tx_port | input | 5 | Transmit port number |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence number |
| irq | output | 1 | Interrupt, raw pending gated by enable |

## Verification
A strobe or register write sampled at edge t fills its pending slot at t. The entry then reaches the queue at edge t+1, where it becomes visible on `reg_rdata` and `irq`. A pin edge needs two more edges for the synchroniser, so the pin entry appears at t+3. Several strobes raised together arrive at edges t+1, t+2 and so on, in priority order. The bench's behavioural model applies these same latencies edge by edge and compares `reg_rdata` and `irq` a quarter period after every edge. Directed reads are timed to sample only after the last relevant edge has passed.

// File: rtl/ts_evt_pkg.sv
package ts_evt_pkg;

   localparam int TS_W   = 32;
   localparam int ADDR_W = 4;

   typedef enum logic [3:0] {
      KIND_SWPUSH = 4'd0,
      KIND_WRAP   = 4'd1,
      KIND_HALF   = 4'd2,
      KIND_PIN    = 4'd3,
      KIND_RX     = 4'd4,
      KIND_TX     = 4'd5
   } ev_kind_e;

   typedef struct packed {
      logic [2:0]  rsvd;
      logic [4:0]  port;
      logic [3:0]  kind;
      logic [3:0]  msg;
      logic [15:0] seq;
   } ev_desc_t;

   typedef struct packed {
      ev_desc_t        desc;
      logic [TS_W-1:0] ts;
   } ev_entry_t;

   localparam int EVT_W = $bits(ev_entry_t);

   localparam logic [ADDR_W-1:0] RA_CTRL  = 4'd0;
   localparam logic [ADDR_W-1:0] RA_PUSH  = 4'd1;
   localparam logic [ADDR_W-1:0] RA_LDVAL = 4'd2;
   localparam logic [ADDR_W-1:0] RA_LDGO  = 4'd3;
   localparam logic [ADDR_W-1:0] RA_RAW   = 4'd4;
   localparam logic [ADDR_W-1:0] RA_MASK  = 4'd5;
   localparam logic [ADDR_W-1:0] RA_IEN   = 4'd6;
   localparam logic [ADDR_W-1:0] RA_POP   = 4'd7;
   localparam logic [ADDR_W-1:0] RA_EVLO  = 4'd8;
   localparam logic [ADDR_W-1:0] RA_EVHI  = 4'd9;
   localparam logic [ADDR_W-1:0] RA_OVF   = 4'd10;

   function automatic ev_entry_t mk_entry(input ev_kind_e k, input logic [4:0] port,
                                          input logic [3:0] msg, input logic [15:0] seq,
                                          input logic [TS_W-1:0] ts);
      ev_entry_t e;
      e.desc.rsvd = 3'b000;
      e.desc.port = port;
      e.desc.kind = k;
      e.desc.msg  = msg;
      e.desc.seq  = seq;
      e.ts        = ts;
      return e;
   endfunction

endpackage

// File: rtl/ts_counter.sv
module ts_counter #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         wrap,
   output logic         half
);

   localparam logic [W-1:0] HALF_M1 = {1'b0, {(W-1){1'b1}}};

   logic [W-1:0] cnt_q;
   logic         step;

   assign step = en && !load;
   assign wrap = step && (&cnt_q);
   assign half = step && (cnt_q == HALF_M1);
   assign cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (load)  cnt_q <= load_val;
      else if (en)    cnt_q <= cnt_q + W'(1);
   end

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !load) |=> (cnt_q == $past(cnt_q) + W'(1)));

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !load) |=> $stable(cnt_q));

   // R2
   cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/ts_pin_sync.sv
module ts_pin_sync #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin,
   output logic [N-1:0] rise
);

   for (genvar k = 0; k < N; k++) begin : g_pin
      logic s1_q, s2_q, s3_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
         end else begin
            s1_q <= pin[k];
            s2_q <= s1_q;
            s3_q <= s2_q;
         end
      end
      assign rise[k] = s2_q && !s3_q;

      // R5
      pin_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rise[k] |=> !rise[k]);
   end

endmodule

// File: rtl/ts_evt_arb.sv
module ts_evt_arb #(
   parameter int NSRC = 9,
   parameter int DW   = 64
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NSRC-1:0]           req,
   input  logic [NSRC-1:0][DW-1:0]   din,
   output logic                      out_valid,
   output logic [DW-1:0]             dout,
   output logic                      collide
);

   localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   logic [NSRC-1:0]         pend_q;
   logic [NSRC-1:0]         grant;
   logic [NSRC-1:0][DW-1:0] slot_q;
   logic [IDX_W-1:0]        gidx;

   always_comb begin
      grant = '0;
      gidx  = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (pend_q[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            gidx     = IDX_W'(i);
         end
      end
   end

   assign out_valid = |pend_q;
   assign dout      = slot_q[gidx];
   assign collide   = |(req & pend_q & ~grant);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         slot_q <= '0;
      end else begin
         for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!pend_q[i] || grant[i])) begin
               pend_q[i] <= 1'b1;
               slot_q[i] <= din[i];
            end else if (grant[i]) begin
               pend_q[i] <= 1'b0;
            end
         end
      end
   end

   // R10
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R10
   drain_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && req == '0) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

endmodule

// File: rtl/ts_evt_fifo.sv
module ts_evt_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic          empty,
   output logic          full
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr_q];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + PTR_W'(1);
         if (do_pop)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + PTR_W'(1);
         cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   // R11
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   // R8
   pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !empty) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

   // R8
   pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && empty) |=> empty);

endmodule

// File: rtl/ts_event_unit.sv
module ts_event_unit
   import ts_evt_pkg::*;
#(
   parameter int NPIN  = 4,
   parameter int DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NPIN-1:0]   hw_pin,
   input  logic              rx_stb,
   input  logic [4:0]        rx_port,
   input  logic [3:0]        rx_msg,
   input  logic [15:0]       rx_seq,
   input  logic              tx_stb,
   input  logic [4:0]        tx_port,
   input  logic [3:0]        tx_msg,
   input  logic [15:0]       tx_seq,
   output logic              irq
);

   localparam int SRC_WRAP = 0;
   localparam int SRC_HALF = 1;
   localparam int SRC_PUSH = 2;
   localparam int SRC_PIN0 = 3;
   localparam int SRC_RX   = SRC_PIN0 + NPIN;
   localparam int SRC_TX   = SRC_RX + 1;
   localparam int NSRC     = SRC_TX + 1;
   localparam int PIN_LSB  = 8;
   localparam logic [31:0] CTRL_MASK = 32'h3 | (((32'd1 << NPIN) - 32'd1) << PIN_LSB);
   localparam logic [TS_W-1:0] HALF_TS = {1'b1, {(TS_W-1){1'b0}}};

   if (NPIN < 1 || NPIN > 4) begin : g_bad_npin
      $error("NPIN must be 1 to 4");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [31:0]     ctrl_q, ldval_q;
   logic            ien_q, ovf_q;
   logic            unit_en;
   logic            wr_push, wr_ldgo, wr_pop, wr_ovfclr;
   logic [TS_W-1:0] cnt;
   logic            wrap, half;
   logic [NPIN-1:0] rise;
   logic [NSRC-1:0] src_req;
   logic [NSRC-1:0][EVT_W-1:0] src_evt;
   logic            arb_valid, collide;
   logic [EVT_W-1:0] arb_evt;
   ev_entry_t       head;
   logic            q_empty, q_full;
   logic            raw_pend, mask_pend;

   assign unit_en   = ctrl_q[0];
   assign wr_push   = reg_wr && (reg_addr == RA_PUSH) && reg_wdata[0];
   assign wr_ldgo   = reg_wr && (reg_addr == RA_LDGO) && reg_wdata[0];
   assign wr_pop    = reg_wr && (reg_addr == RA_POP)  && reg_wdata[0];
   assign wr_ovfclr = reg_wr && (reg_addr == RA_OVF)  && reg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         ldval_q <= '0;
         ien_q   <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == RA_CTRL)  ctrl_q  <= reg_wdata & CTRL_MASK;
         if (reg_wr && reg_addr == RA_LDVAL) ldval_q <= reg_wdata;
         if (reg_wr && reg_addr == RA_IEN)   ien_q   <= reg_wdata[0];
         ovf_q <= (ovf_q && !wr_ovfclr) || (arb_valid && q_full) || collide;
      end
   end

   ts_counter #(.W(TS_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(unit_en), .load(wr_ldgo),
      .load_val(ldval_q), .cnt(cnt), .wrap(wrap), .half(half)
   );

   ts_pin_sync #(.N(NPIN)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(hw_pin), .rise(rise)
   );

   assign src_req[SRC_WRAP] = wrap;
   assign src_evt[SRC_WRAP] = mk_entry(KIND_WRAP, 5'd0, 4'd0, 16'd0, '0);
   assign src_req[SRC_HALF] = half;
   assign src_evt[SRC_HALF] = mk_entry(KIND_HALF, 5'd0, 4'd0, 16'd0, HALF_TS);
   assign src_req[SRC_PUSH] = unit_en && wr_push;
   assign src_evt[SRC_PUSH] = mk_entry(KIND_SWPUSH, 5'd0, 4'd0, 16'd0, cnt);

   for (genvar k = 0; k < NPIN; k++) begin : g_pin_src
      assign src_req[SRC_PIN0+k] = unit_en && rise[k] && ctrl_q[PIN_LSB+k];
      assign src_evt[SRC_PIN0+k] = mk_entry(KIND_PIN, 5'(k + 1), 4'd0, 16'd0, cnt);
   end

   assign src_req[SRC_RX] = unit_en && rx_stb;
   assign src_evt[SRC_RX] = mk_entry(KIND_RX, rx_port, rx_msg, rx_seq, cnt);
   assign src_req[SRC_TX] = unit_en && tx_stb;
   assign src_evt[SRC_TX] = mk_entry(KIND_TX, tx_port, tx_msg, tx_seq, cnt);

   ts_evt_arb #(.NSRC(NSRC), .DW(EVT_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(src_req), .din(src_evt),
      .out_valid(arb_valid), .dout(arb_evt), .collide(collide)
   );

   ts_evt_fifo #(.DEPTH(DEPTH), .DW(EVT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(arb_valid && !q_full), .din(arb_evt),
      .pop(wr_pop), .dout(head), .empty(q_empty), .full(q_full)
   );

   assign raw_pend  = !q_empty || ctrl_q[1];
   assign mask_pend = raw_pend && ien_q;
   assign irq       = mask_pend;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL:  reg_rdata = ctrl_q;
         RA_LDVAL: reg_rdata = ldval_q;
         RA_RAW:   reg_rdata = {31'd0, raw_pend};
         RA_MASK:  reg_rdata = {31'd0, mask_pend};
         RA_IEN:   reg_rdata = {31'd0, ien_q};
         RA_EVLO:  reg_rdata = q_empty ? '0 : head.ts;
         RA_EVHI:  reg_rdata = q_empty ? '0 : head.desc;
         RA_OVF:   reg_rdata = {31'd0, ovf_q};
         default:  reg_rdata = '0;
      endcase
   end

   // R11
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_valid && q_full) |=> ovf_q);

   // R11
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !wr_ovfclr) |=> ovf_q);

   // R12
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_en && !arb_valid) |=> !arb_valid);

endmodule

// File: tb/ts_event_unit_tb.sv
module ts_event_unit_tb;

   localparam int NS = 9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  hw_pin = '0;
   logic        rx_stb = 1'b0, tx_stb = 1'b0;
   logic [4:0]  rx_port = '0, tx_port = '0;
   logic [3:0]  rx_msg = '0, tx_msg = '0;
   logic [15:0] rx_seq = '0, tx_seq = '0;
   logic        irq;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   ts_event_unit u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_pin(hw_pin),
      .rx_stb(rx_stb), .rx_port(rx_port), .rx_msg(rx_msg), .rx_seq(rx_seq),
      .tx_stb(tx_stb), .tx_port(tx_port), .tx_msg(tx_msg), .tx_seq(tx_seq),
      .irq(irq)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_cnt, m_ctrl, m_lv;
   logic        m_ie, m_ovf;
   logic [NS-1:0] m_pend;
   logic [63:0] m_slot [NS];
   logic [63:0] mq [$];
   logic [3:0]  m_s1, m_s2, m_s3;

   function automatic logic [63:0] ent(input logic [3:0] kind, input logic [4:0] port,
                                       input logic [3:0] msg, input logic [15:0] seq,
                                       input logic [31:0] ts);
      return {3'b000, port, kind, msg, seq, ts};
   endfunction

   function automatic logic [31:0] m_read(input logic [3:0] a);
      logic raw;
      raw = (mq.size() > 0) || m_ctrl[1];
      case (a)
         4'd0:  return m_ctrl;
         4'd2:  return m_lv;
         4'd4:  return {31'd0, raw};
         4'd5:  return {31'd0, raw & m_ie};
         4'd6:  return {31'd0, m_ie};
         4'd8:  return (mq.size() > 0) ? mq[0][31:0] : 32'd0;
         4'd9:  return (mq.size() > 0) ? mq[0][63:32] : 32'd0;
         4'd10: return {31'd0, m_ovf};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [3:0] a);
      case (a)
         4'd4, 4'd5, 4'd6: return "R9";
         4'd8, 4'd9:       return "R8";
         4'd10:            return "R11";
         default:          return "R2";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_ctrl = '0; m_lv = '0; m_ie = 0; m_ovf = 0;
         m_pend = '0; mq.delete();
         m_s1 = '0; m_s2 = '0; m_s3 = '0;
         for (int i = 0; i < NS; i++) m_slot[i] = '0;
      end else begin
         logic wr, en, ovfset, clr, ld;
         logic [3:0] a, rise;
         logic [31:0] d;
         logic [NS-1:0] nreq;
         logic [63:0] ndat [NS];
         int g, sz;
         wr = reg_wr; a = reg_addr; d = reg_wdata; en = m_ctrl[0];
         ovfset = 0;
         ld = wr && a == 4'd3 && d[0];
         // move one held event into the queue, then apply a pop
         g = -1;
         for (int i = NS - 1; i >= 0; i--) if (m_pend[i]) g = i;
         sz = mq.size();
         if (wr && a == 4'd7 && d[0] && sz > 0) void'(mq.pop_front());
         if (g >= 0) begin
            if (sz < 16) mq.push_back(m_slot[g]); else ovfset = 1;
            m_pend[g] = 0;
         end
         // new events
         rise = m_s2 & ~m_s3;
         nreq = '0;
         nreq[0] = en && !ld && m_cnt == 32'hFFFF_FFFF;
         ndat[0] = ent(4'd1, 5'd0, 4'd0, 16'd0, 32'd0);
         nreq[1] = en && !ld && m_cnt == 32'h7FFF_FFFF;
         ndat[1] = ent(4'd2, 5'd0, 4'd0, 16'd0, 32'h8000_0000);
         nreq[2] = en && wr && a == 4'd1 && d[0];
         ndat[2] = ent(4'd0, 5'd0, 4'd0, 16'd0, m_cnt);
         for (int k = 0; k < 4; k++) begin
            nreq[3+k] = en && rise[k] && m_ctrl[8+k];
            ndat[3+k] = ent(4'd3, 5'(k + 1), 4'd0, 16'd0, m_cnt);
         end
         nreq[7] = en && rx_stb;
         ndat[7] = ent(4'd4, rx_port, rx_msg, rx_seq, m_cnt);
         nreq[8] = en && tx_stb;
         ndat[8] = ent(4'd5, tx_port, tx_msg, tx_seq, m_cnt);
         for (int i = 0; i < NS; i++) begin
            if (nreq[i]) begin
               if (m_pend[i]) ovfset = 1;
               else begin m_pend[i] = 1; m_slot[i] = ndat[i]; end
            end
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = hw_pin;
         if (ld) m_cnt = m_lv;
         else if (en) m_cnt = m_cnt + 32'd1;
         clr = wr && a == 4'd10 && d[0];
         if (wr && a == 4'd0) m_ctrl = d & 32'h0000_0F03;
         if (wr && a == 4'd2) m_lv = d;
         if (wr && a == 4'd6) m_ie = d[0];
         m_ovf = (m_ovf && !clr) || ovfset;
      end
      #5;
      if (rst_n && !done) begin
         logic [31:0] er;
         logic ei;
         er = m_read(reg_addr);
         ei = ((mq.size() > 0) || m_ctrl[1]) && m_ie;
         tests++;
         if (reg_rdata !== er) begin
            fails++;
            $display("FAIL %s model read addr %0d: actual %h expected %h",
                     tag_of(reg_addr), reg_addr, reg_rdata, er);
         end
         tests++;
         if (irq !== ei) begin
            fails++;
            $display("FAIL R9 model irq: actual %b expected %b", irq, ei);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      @(posedge clk);
      #5;
      v = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic irq_now(output logic v);
      @(posedge clk);
      #5;
      v = irq;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, ts0;
      logic b;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd0, v);  chk("R1 ctrl", v, 32'd0);
      rd(4'd4, v);  chk("R1 raw", v, 32'd0);
      rd(4'd10, v); chk("R1 ovf", v, 32'd0);
      irq_now(b);   chk("R1 irq", {31'd0, b}, 32'd0);

      // R12 disabled unit queues nothing
      wr(4'd1, 32'd1);
      idle(3);
      rd(4'd4, v);  chk("R12 push while off", v, 32'd0);

      // R2, R3 load then push
      wr(4'd0, 32'd1);
      wr(4'd2, 32'd100);
      wr(4'd3, 32'd1);
      wr(4'd1, 32'd1);
      rd(4'd8, v);  chk("R3 push ts after load (R2)", v, 32'd101);
      rd(4'd9, v);  chk("R7 push descriptor", v, 32'h0000_0000);
      wr(4'd7, 32'd1);
      rd(4'd4, v);  chk("R8 pop to empty", v, 32'd0);
      wr(4'd7, 32'd1);
      rd(4'd4, v);  chk("R8 pop on empty", v, 32'd0);
      rd(4'd8, v);  chk("R8 empty low reads 0", v, 32'd0);

      // R4 half-wrap and wrap
      wr(4'd2, 32'h7FFF_FFFE);
      wr(4'd3, 32'd1);
      idle(4);
      rd(4'd8, v);  chk("R4 half ts", v, 32'h8000_0000);
      rd(4'd9, v);  chk("R4 half descriptor", v, 32'h0020_0000);
      wr(4'd7, 32'd1);
      wr(4'd2, 32'hFFFF_FFFE);
      wr(4'd3, 32'd1);
      idle(4);
      rd(4'd8, v);  chk("R4 wrap ts", v, 32'd0);
      rd(4'd9, v);  chk("R4 wrap descriptor", v, 32'h0010_0000);
      wr(4'd7, 32'd1);
      wr(4'd2, 32'hFFFF_FFFF);
      wr(4'd3, 32'd1);
      idle(3);
      wr(4'd0, 32'd0);
      rd(4'd4, v);  chk("R4 load lands on all ones, wrap only once", v, 32'd1);
      wr(4'd7, 32'd1);
      rd(4'd4, v);  chk("R4 single wrap entry", v, 32'd0);

      // R5 pins
      wr(4'd0, 32'h0000_0F01);
      @(negedge clk) hw_pin = 4'b0100;
      idle(3);
      hw_pin = 4'b0000;
      idle(5);
      rd(4'd9, v);  chk("R5 pin 3 descriptor", v, 32'h0330_0000);
      wr(4'd7, 32'd1);
      wr(4'd0, 32'h0000_0701);
      @(negedge clk) hw_pin = 4'b1000;
      idle(3);
      hw_pin = 4'b0000;
      idle(5);
      rd(4'd4, v);  chk("R5 masked pin queues nothing", v, 32'd0);

      // R6, R10 same-cycle push, receive, transmit
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 32'd1;
      rx_stb = 1'b1; rx_port = 5'd2; rx_msg = 4'h3; rx_seq = 16'hABCD;
      tx_stb = 1'b1; tx_port = 5'd1; tx_msg = 4'h0; tx_seq = 16'h1234;
      @(negedge clk);
      reg_wr = 1'b0; rx_stb = 1'b0; tx_stb = 1'b0;
      idle(4);
      rd(4'd9, v);  chk("R10 first is push", v, 32'h0000_0000);
      rd(4'd8, ts0);
      wr(4'd7, 32'd1);
      rd(4'd9, v);  chk("R6 rx descriptor (R10 second)", v, 32'h0243_ABCD);
      rd(4'd8, v);  chk("R10 rx shares push ts", v, ts0);
      wr(4'd7, 32'd1);
      rd(4'd9, v);  chk("R6 tx descriptor (R10 third)", v, 32'h0150_1234);
      rd(4'd8, v);  chk("R10 tx shares push ts", v, ts0);
      wr(4'd7, 32'd1);

      // R9 interrupt gating and test bit
      wr(4'd6, 32'd1);
      irq_now(b);   chk("R9 empty no irq", {31'd0, b}, 32'd0);
      wr(4'd0, 32'h0000_0F03);
      rd(4'd4, v);  chk("R9 test bit raw", v, 32'd1);
      rd(4'd5, v);  chk("R9 test bit masked", v, 32'd1);
      irq_now(b);   chk("R9 test bit irq", {31'd0, b}, 32'd1);
      wr(4'd0, 32'h0000_0F01);
      wr(4'd6, 32'd0);
      wr(4'd1, 32'd1);
      rd(4'd4, v);  chk("R9 raw with entry", v, 32'd1);
      rd(4'd5, v);  chk("R9 masked off", v, 32'd0);
      irq_now(b);   chk("R9 irq off", {31'd0, b}, 32'd0);
      wr(4'd6, 32'd1);
      irq_now(b);   chk("R9 irq on", {31'd0, b}, 32'd1);
      wr(4'd7, 32'd1);
      irq_now(b);   chk("R9 irq after pop", {31'd0, b}, 32'd0);

      // R11 overflow
      for (int i = 0; i < 18; i++) wr(4'd1, 32'd1);
      idle(2);
      rd(4'd10, v); chk("R11 overflow set", v, 32'd1);
      wr(4'd10, 32'd1);
      rd(4'd10, v); chk("R11 overflow cleared", v, 32'd0);
      for (int i = 0; i < 15; i++) wr(4'd7, 32'd1);
      rd(4'd4, v);  chk("R11 one entry left of 16", v, 32'd1);
      wr(4'd7, 32'd1);
      rd(4'd4, v);  chk("R11 exactly 16 kept", v, 32'd0);

      idle(2);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule